// File: doc/BRIEF.md
# Multi-Line Chip-Select Sequencer

This block drives the chip-select lines of a serial peripheral master. It owns sixteen select outputs. Each line has its own active polarity and its own enable. A frame request carries a mask of the lines to address. When at most four bits are set, the sequencer asserts those lines and waits a programmable lead time. It then raises a go level towards the shift engine and keeps the lines asserted until the shift engine reports the end of the transfer. After that it holds the lines for a programmable trail time and then releases them.

A request whose mask has more than four bits set is refused. The refusal shows as a one-cycle error pulse, and every line stays at its inactive level. While a frame is in progress, new requests are ignored. The lead and trail counts are captured when a request is accepted, so changing the configuration during a frame does not disturb that frame. Every select line comes straight from a flip-flop, which keeps the lines free of glitches.

Top module: `csel_gen`

## Requirements
- R1: During reset and on the first clock edge after reset, every select line is high (the inactive level of an active-low line when `act_level_i` is 0), and `go_o` and `err_o` are 0.
- R2: At the clock edge that samples `start_i` in the idle state with a mask of four or fewer set bits, each line whose mask bit is 1 and whose enable bit is 1 goes to its active level. The line stays there until release.
- R3: At the clock edge that samples `start_i` in the idle state with more than four mask bits set, `err_o` becomes 1 for exactly that cycle. All lines stay inactive and `go_o` stays 0.
- R4: Bit i of `act_level_i` sets the active level of line i (1 means active high, 0 means active low). The inactive level is the opposite value. A line shows the level from the previous clock edge's `act_level_i`.
- R5: A line whose bit in `line_en_i` is 0 sits at its inactive level at every clock edge, whatever the mask and the state.
- R6: With lead count L (0 to 255) captured at acceptance, `go_o` rises exactly L clock edges after the lines go active. For L = 0 it rises at the same edge.
- R7: `go_o` stays 1 until `done_i` is sampled while `go_o` is 1, and it falls at that edge. A `done_i` strobe during the lead wait is ignored.
- R8: With trail count T (0 to 255) captured at acceptance, the lines return to inactive exactly T edges after `go_o` falls. For T = 0 they return at the same edge.
- R9: A `start_i` that arrives while a frame is in progress is ignored. It causes no error pulse and does not change the addressed lines.
- R10: A request sampled at the first edge after the lines are released is accepted.
- R11: Changes to `lead_cfg_i`, `trail_cfg_i` or `sel_mask_i` after acceptance do not affect the current frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request |
| sel_mask_i | input | 16 | Lines addressed by the request |
| done_i | input | 1 | Transfer-complete strobe from the shift engine |
| lead_cfg_i | input | 8 | Cycles from line assertion to go |
| trail_cfg_i | input | 8 | Cycles from end of transfer to release |
| act_level_i | input | 16 | Per-line active level (1 = high) |
| line_en_i | input | 16 | Per-line enable |
| sel_o | output | 16 | Registered select lines |
| go_o | output | 1 | Shift engine may run |
| err_o | output | 1 | One-cycle pulse on a refused request |

## Verification
Two situations put events in the same cycle. In the first, a new request (with an over-wide mask and new lead and trail values) arrives in the very first cycle after acceptance. The bench judges it by the absence of an error pulse and by the go and release edges still falling at the counts captured earlier. In the second, a done strobe coincides with the last lead cycle or an earlier one. The bench expects `go_o` to rise on schedule anyway and to stay high until the later genuine done. Each frame also begins at the edge right after the previous release, so release and acceptance sit in adjacent cycles.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_TRAIL = 2'd3
    } csel_state_e;
endpackage

// File: rtl/csel_popcount.sv
`timescale 1ns/1ps
module csel_popcount #(
    parameter int W     = 16,
    parameter int LIMIT = 4
) (
    input  logic [W-1:0] vec_i,
    output logic         over_o
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] part [W+1];

    assign part[0] = '0;
    for (genvar g = 0; g < W; g++) begin : g_sum
        assign part[g+1] = part[g] + CW'(vec_i[g]);
    end

    assign over_o = part[W] > CW'(LIMIT);
endmodule

// File: rtl/csel_seq.sv
`timescale 1ns/1ps
module csel_seq
    import csel_pkg::*;
#(
    parameter int N  = 16,
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic          reject_i,
    input  logic          done_i,
    input  logic [N-1:0]  mask_i,
    input  logic [DW-1:0] lead_i,
    input  logic [DW-1:0] trail_i,
    output logic          hold_d_o,
    output logic [N-1:0]  mask_d_o,
    output logic          go_o,
    output logic          err_o,
    output logic          idle_o
);
    typedef struct packed {
        csel_state_e   state;
        logic [DW-1:0] cnt;
        logic [DW-1:0] trl;
        logic [N-1:0]  mask;
        logic          go;
        logic          err;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.err = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (reject_i) begin
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.mask = mask_i;
                        seq_d.trl  = trail_i;
                        if (lead_i == '0) begin
                            seq_d.state = ST_HOLD;
                            seq_d.go    = 1'b1;
                        end else begin
                            seq_d.state = ST_LEAD;
                            seq_d.cnt   = lead_i;
                        end
                    end
                end
            end
            ST_LEAD: begin
                if (seq_q.cnt <= DW'(1)) begin
                    seq_d.state = ST_HOLD;
                    seq_d.go    = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - DW'(1);
                end
            end
            ST_HOLD: begin
                if (done_i) begin
                    seq_d.go = 1'b0;
                    if (seq_q.trl == '0) begin
                        seq_d.state = ST_IDLE;
                    end else begin
                        seq_d.state = ST_TRAIL;
                        seq_d.cnt   = seq_q.trl;
                    end
                end
            end
            ST_TRAIL: begin
                if (seq_q.cnt <= DW'(1)) begin
                    seq_d.state = ST_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - DW'(1);
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{state: ST_IDLE, cnt: '0, trl: '0, mask: '0, go: 1'b0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign hold_d_o = (seq_d.state != ST_IDLE);
    assign mask_d_o = seq_d.mask;
    assign go_o     = seq_q.go;
    assign err_o    = seq_q.err;
    assign idle_o   = (seq_q.state == ST_IDLE);
endmodule

// File: rtl/csel_drive.sv
`timescale 1ns/1ps
module csel_drive #(
    parameter int           N       = 16,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         hold_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] sel_o
);
    logic [N-1:0] sel_d, sel_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        always_comb begin
            if (hold_i && mask_i[g] && en_i[g]) begin
                sel_d[g] = lvl_i[g];
            end else begin
                sel_d[g] = ~lvl_i[g];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q <= RST_VAL;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/csel_gen.sv
`timescale 1ns/1ps
module csel_gen #(
    parameter int NUM_LINES  = 16,
    parameter int MAX_ACTIVE = 4,
    parameter int DLY_W      = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [NUM_LINES-1:0] sel_mask_i,
    input  logic                 done_i,
    input  logic [DLY_W-1:0]     lead_cfg_i,
    input  logic [DLY_W-1:0]     trail_cfg_i,
    input  logic [NUM_LINES-1:0] act_level_i,
    input  logic [NUM_LINES-1:0] line_en_i,
    output logic [NUM_LINES-1:0] sel_o,
    output logic                 go_o,
    output logic                 err_o
);
    localparam logic [NUM_LINES-1:0] SEL_RST = '1;

    logic                 over_w;
    logic                 hold_d_w;
    logic [NUM_LINES-1:0] mask_d_w;
    logic                 idle_w;

    csel_popcount #(.W(NUM_LINES), .LIMIT(MAX_ACTIVE)) u_cnt (
        .vec_i  (sel_mask_i),
        .over_o (over_w)
    );

    csel_seq #(.N(NUM_LINES), .DW(DLY_W)) u_seq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_i),
        .reject_i (over_w),
        .done_i   (done_i),
        .mask_i   (sel_mask_i),
        .lead_i   (lead_cfg_i),
        .trail_i  (trail_cfg_i),
        .hold_d_o (hold_d_w),
        .mask_d_o (mask_d_w),
        .go_o     (go_o),
        .err_o    (err_o),
        .idle_o   (idle_w)
    );

    csel_drive #(.N(NUM_LINES), .RST_VAL(SEL_RST)) u_drv (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hold_i (hold_d_w),
        .mask_i (mask_d_w),
        .en_i   (line_en_i),
        .lvl_i  (act_level_i),
        .sel_o  (sel_o)
    );
endmodule

// File: rtl/csel_gen_chk.sv
`timescale 1ns/1ps
module csel_gen_chk #(
    parameter int N    = 16,
    parameter int DW   = 8,
    parameter int MAXA = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          start_i,
    input logic [N-1:0]  sel_mask_i,
    input logic          done_i,
    input logic [DW-1:0] lead_cfg_i,
    input logic [N-1:0]  act_level_i,
    input logic [N-1:0]  line_en_i,
    input logic [N-1:0]  sel_o,
    input logic          go_o,
    input logic          err_o,
    input logic          idle_w
);
    logic          past_ok;
    logic [DW:0]   since_q;
    logic [DW:0]   lead_lat_q;
    logic          accept_w;

    assign accept_w = idle_w && start_i && ($countones(sel_mask_i) <= MAXA);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            past_ok    <= 1'b0;
            since_q    <= '0;
            lead_lat_q <= '0;
        end else begin
            past_ok <= 1'b1;
            if (accept_w) begin
                since_q    <= '0;
                lead_lat_q <= {1'b0, lead_cfg_i};
            end else if (since_q != '1) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    // R2: never more than MAXA lines at their active level
    p_max_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok |-> ($countones(sel_o ~^ $past(act_level_i)) <= MAXA));

    // R3: an error pulse follows only an over-wide request
    p_err_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> $past(start_i && ($countones(sel_mask_i) > MAXA)));

    // R3: a refused request leaves every line inactive and go low
    p_err_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o && past_ok) |-> (((sel_o ~^ $past(act_level_i)) == '0) && !go_o));

    // R5: disabled lines stay inactive
    p_disabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok |-> (((sel_o ~^ $past(act_level_i)) & ~$past(line_en_i)) == '0));

    // R6: go rises exactly the captured lead count after acceptance
    p_go_lead_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && $rose(go_o)) |-> (since_q == lead_lat_q));

    // R7: a done strobe while go is high drops go at the next edge
    p_go_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (go_o && done_i) |=> !go_o);
endmodule

bind csel_gen csel_gen_chk #(.N(NUM_LINES), .DW(DLY_W), .MAXA(MAX_ACTIVE)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .sel_mask_i  (sel_mask_i),
    .done_i      (done_i),
    .lead_cfg_i  (lead_cfg_i),
    .act_level_i (act_level_i),
    .line_en_i   (line_en_i),
    .sel_o       (sel_o),
    .go_o        (go_o),
    .err_o       (err_o),
    .idle_w      (idle_w)
);

// File: tb/tb_csel_gen.sv
`timescale 1ns/1ps
module tb_csel_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] mask;
    logic        done;
    logic [7:0]  lead_cfg;
    logic [7:0]  trail_cfg;
    logic [15:0] lvl;
    logic [15:0] en;
    logic [15:0] sel;
    logic        go;
    logic        err;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    csel_gen dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .sel_mask_i  (mask),
        .done_i      (done),
        .lead_cfg_i  (lead_cfg),
        .trail_cfg_i (trail_cfg),
        .act_level_i (lvl),
        .line_en_i   (en),
        .sel_o       (sel),
        .go_o        (go),
        .err_o       (err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, a, e);
        end
    endtask

    function automatic logic [15:0] exp_sel(input logic [15:0] m, input logic [15:0] e,
                                            input logic [15:0] l);
        return ~((m & e) ^ l);
    endfunction

    function automatic logic [15:0] mk_mask(input int pc, input int seed);
        logic [15:0] m = '0;
        for (int j = 0; j < pc; j++) m[(j * 5 + seed) % 16] = 1'b1;
        return m;
    endfunction

    task automatic frame(input logic [15:0] m, input int ld, input int tr,
                         input logic [15:0] l, input logic [15:0] e, input int hold);
        logic [15:0] act_v;
        logic [15:0] idle_v;
        @(negedge clk);
        start = 1'b1; mask = m; lvl = l; en = e; done = 1'b0;
        lead_cfg = 8'(ld); trail_cfg = 8'(tr);
        act_v  = exp_sel(m, e, l);
        idle_v = ~l;
        @(posedge clk); #1;
        if ($countones(m) > 4) begin
            chk(err == 1'b1, "R3 err pulse", 32'(err), 1);
            chk(sel == idle_v, "R3 lines inactive", 32'(sel), 32'(idle_v));
            chk(go == 1'b0, "R3 no go", 32'(go), 0);
            @(negedge clk); start = 1'b0;
            @(posedge clk); #1;
            chk(err == 1'b0, "R3 single cycle", 32'(err), 0);
            chk(sel == idle_v, "R3 still inactive", 32'(sel), 32'(idle_v));
            return;
        end
        chk(sel == act_v, "R2 R4 R5 R10 assert", 32'(sel), 32'(act_v));
        chk(go == (ld == 0), "R6 go lead0", 32'(go), 32'(ld == 0));
        chk(err == 1'b0, "R2 no err", 32'(err), 0);
        for (int c = 1; c <= ld + hold; c++) begin
            @(negedge clk);
            if (c == 1) begin
                start = 1'b1; mask = 16'hFFFF;
                lead_cfg = ~8'(ld); trail_cfg = ~8'(tr);
            end else begin
                start = 1'b0; mask = 16'h0000;
            end
            done = (c == ld + hold) || (c == 1 && ld >= 1);
            @(posedge clk); #1;
            chk(err == 1'b0, "R9 busy start no err", 32'(err), 0);
            if (c < ld + hold) begin
                chk(go == (c >= ld), "R6 R7 R11 go timing", 32'(go), 32'(c >= ld));
                chk(sel == act_v, "R2 R9 lines held", 32'(sel), 32'(act_v));
            end else begin
                chk(go == 1'b0, "R7 go drop", 32'(go), 0);
                chk(sel == ((tr == 0) ? idle_v : act_v), "R8 trail0", 32'(sel),
                    32'((tr == 0) ? idle_v : act_v));
            end
        end
        for (int t = 1; t <= tr; t++) begin
            @(negedge clk); done = 1'b0; start = 1'b0;
            @(posedge clk); #1;
            chk(sel == ((t == tr) ? idle_v : act_v), "R8 R11 trail", 32'(sel),
                32'((t == tr) ? idle_v : act_v));
            chk(go == 1'b0, "R8 go low in trail", 32'(go), 0);
        end
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; mask = '0; done = 1'b0;
        lead_cfg = '0; trail_cfg = '0; lvl = '0; en = '1;
        repeat (3) @(posedge clk);
        #1;
        chk(sel == 16'hFFFF, "R1 sel in reset", 32'(sel), 32'hFFFF);
        chk(go == 1'b0 && err == 1'b0, "R1 go err in reset", 32'({go, err}), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(sel == 16'hFFFF, "R1 sel after reset", 32'(sel), 32'hFFFF);
        chk(go == 1'b0 && err == 1'b0, "R1 go err after reset", 32'({go, err}), 0);

        for (int ld = 0; ld < 4; ld++) begin
            for (int tr = 0; tr < 4; tr++) begin
                for (int pc = 0; pc <= 6; pc++) begin
                    logic [15:0] l;
                    logic [15:0] e;
                    l = 16'hA5C3 << (pc + ld);
                    e = (pc % 3 == 0) ? 16'hFFFF : (16'hF0FF >> tr);
                    frame(mk_mask(pc, ld * 4 + tr), ld, tr, l, e, 1 + (pc % 3));
                end
            end
        end
        frame(16'h8001, 255, 255, 16'h0000, 16'hFFFF, 2);
        frame(16'hFFFF, 5, 5, 16'h00FF, 16'hFFFF, 1);
        frame(16'h0F00, 2, 3, 16'hFFFF, 16'h0000, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule